// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is a single node of a two-dimensional mesh on-chip network. It has five bidirectional flit ports: one to the local processing tile and one each towards the north, south, east and west neighbours. Every flit is 32 bits wide. Each input port has exactly one FIFO. The flit at the head of a FIFO is either the header of a new packet or a flit that belongs to a packet already in flight.

When a header reaches the head of its FIFO, the router picks an output by dimension-ordered routing. It first corrects the X coordinate and then the Y coordinate. A round-robin arbiter on each output grants one of the competing inputs. The granted input keeps the output for the whole packet. The second flit of a packet gives the number of payload flits that follow it, and a per-input counter uses that number to find the last flit. The path is released after the last flit has been transferred. Every link uses valid/ready handshaking, so a flit never moves into a full FIFO.

A mesh is built by instantiating one router per tile, giving each instance its own coordinates, and connecting the directional ports of neighbouring routers to each other.

Top module: `mesh_xy_router`

## Requirements
- R1: After reset, every input port shows ready high and every output port shows valid low.
- R2: A header flit carries the destination X in bits [7:4] and the destination Y in bits [3:0]. Output ports are numbered local=0, north=1, south=2, east=3, west=4. If the destination X is greater than the router's X, the packet goes east. If it is smaller, the packet goes west. If the X values are equal, a larger Y goes north and a smaller Y goes south. If both coordinates match, the packet goes to the local port.
- R3: The second flit carries the payload count N in bits [15:0]. A packet is 2+N flits long, and every flit leaves the router unchanged and in its original order.
- R4: Once an output has been granted to an input, that output carries only flits of that packet until the packet's last flit. Flits of two packets never interleave on an output.
- R5: The output is free again in the cycle after the packet's last flit is transferred. With a zero payload count, the size flit is the last flit. When a next header is already waiting, it is transferred exactly two cycles after the previous packet's last flit.
- R6: When two inputs keep requesting the same output, grants alternate between them.
- R7: A flit transfers only in a cycle where both valid and ready are high. While an output's ready is low, that output keeps its valid high and its flit unchanged.
- R8: An input's ready is low while its FIFO is full, and no flit is lost or duplicated across a stall.
- R9: Packets on disjoint input/output pairs move in the same cycles without stalling each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_flit | input | 5x32 | Incoming flit for each port (index = port number) |
| in_valid | input | 5 | Incoming flit present, one bit per port |
| in_ready | output | 5 | Input FIFO can accept a flit, one bit per port |
| out_flit | output | 5x32 | Outgoing flit for each port |
| out_valid | output | 5 | Outgoing flit present, one bit per port |
| out_ready | input | 5 | Downstream can accept a flit, one bit per port |

## Verification
The assertions assume that every packet is well formed: a header, then a size flit, then exactly as many payload flits as the size flit states. They also assume that an upstream sender keeps a flit on the link until ready accepts it. The stimulus builds every packet from a single helper, so the count field always matches the number of payload flits. Each port's driver advances to its next flit only after a handshake has completed. Downstream ready is either held high or held low over whole windows, so an output stalls only where a test asks for it.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;

    localparam int NPORTS  = 5;
    localparam int COORD_W = 4;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_SOUTH = 3'd2,
        PORT_EAST  = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_SIZE,
        ST_BODY
    } in_state_e;

    // Dimension-ordered choice: settle X, then Y, then deliver locally.
    function automatic port_e xy_route(
        input logic [COORD_W-1:0] here_x,
        input logic [COORD_W-1:0] here_y,
        input logic [COORD_W-1:0] dest_x,
        input logic [COORD_W-1:0] dest_y
    );
        if (dest_x > here_x)      return PORT_EAST;
        else if (dest_x < here_x) return PORT_WEST;
        else if (dest_y > here_y) return PORT_NORTH;
        else if (dest_y < here_y) return PORT_SOUTH;
        else                      return PORT_LOCAL;
    endfunction

endpackage

// File: rtl/flit_fifo.sv
module flit_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] push_data,
    input  logic             push_valid,
    output logic             push_ready,
    output logic [WIDTH-1:0] head_data,
    output logic             head_valid,
    input  logic             pop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ready = (count != CW'(DEPTH));
    assign head_valid = (count != '0);
    assign head_data  = mem[rd_ptr];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && head_valid;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/route_ctrl.sv
module route_ctrl
    import mesh_router_pkg::*;
#(
    parameter int                 CNT_W = 16,
    parameter logic [COORD_W-1:0] MY_X  = '0,
    parameter logic [COORD_W-1:0] MY_Y  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             head_valid,
    input  logic [CNT_W-1:0] head_low,
    input  logic             grant,
    input  logic             sel_ready,
    output logic             req,
    output port_e            req_dir,
    output logic             locked,
    output port_e            lock_dir,
    output logic             pop
);
    in_state_e        state;
    logic [CNT_W-1:0] remaining;

    assign req_dir = xy_route(MY_X, MY_Y, head_low[7:4], head_low[3:0]);
    assign req     = (state == ST_IDLE) && head_valid;
    assign locked  = (state != ST_IDLE);
    assign pop     = locked && head_valid && sel_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            lock_dir  <= PORT_LOCAL;
            remaining <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (grant) begin
                    state    <= ST_HEAD;
                    lock_dir <= req_dir;
                end
                ST_HEAD: if (pop) state <= ST_SIZE;
                ST_SIZE: if (pop) begin
                    remaining <= head_low;
                    state     <= (head_low == '0) ? ST_IDLE : ST_BODY;
                end
                ST_BODY: if (pop) begin
                    remaining <= remaining - 1'b1;
                    if (remaining == CNT_W'(1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    int            winner;
    logic          found;
    int            idx;

    always_comb begin
        gnt    = '0;
        found  = 1'b0;
        winner = 0;
        idx    = 0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
                winner   = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else if (found) ptr <= IW'((winner + 1) % N);
    end
endmodule

// File: rtl/mesh_xy_router.sv
module mesh_xy_router
    import mesh_router_pkg::*;
#(
    parameter int                 FLIT_W     = 32,
    parameter int                 FIFO_DEPTH = 256,
    parameter int                 CNT_W      = 16,
    parameter logic [COORD_W-1:0] MY_X       = '0,
    parameter logic [COORD_W-1:0] MY_Y       = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORTS-1:0][FLIT_W-1:0] in_flit,
    input  logic [NPORTS-1:0]             in_valid,
    output logic [NPORTS-1:0]             in_ready,
    output logic [NPORTS-1:0][FLIT_W-1:0] out_flit,
    output logic [NPORTS-1:0]             out_valid,
    input  logic [NPORTS-1:0]             out_ready
);
    logic [NPORTS-1:0]             head_valid, req, locked, pop, grant, sel_ready;
    logic [NPORTS-1:0][FLIT_W-1:0] head_flit;
    port_e                         req_dir  [NPORTS];
    port_e                         lock_dir [NPORTS];

    // conn[o][i]: input i holds output o
    logic [NPORTS-1:0][NPORTS-1:0] arb_req, arb_gnt, conn;
    logic [NPORTS-1:0]             out_busy;

    for (genvar i = 0; i < NPORTS; i++) begin : g_in
        flit_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push_data  (in_flit[i]),
            .push_valid (in_valid[i]),
            .push_ready (in_ready[i]),
            .head_data  (head_flit[i]),
            .head_valid (head_valid[i]),
            .pop        (pop[i])
        );

        route_ctrl #(.CNT_W(CNT_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_ctrl (
            .clk        (clk),
            .rst        (rst),
            .head_valid (head_valid[i]),
            .head_low   (head_flit[i][CNT_W-1:0]),
            .grant      (grant[i]),
            .sel_ready  (sel_ready[i]),
            .req        (req[i]),
            .req_dir    (req_dir[i]),
            .locked     (locked[i]),
            .lock_dir   (lock_dir[i]),
            .pop        (pop[i])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORTS; o++)
            for (int i = 0; i < NPORTS; i++)
                conn[o][i] = locked[i] && (int'(lock_dir[i]) == o);
    end

    always_comb begin
        for (int o = 0; o < NPORTS; o++) out_busy[o] = |conn[o];
    end

    always_comb begin
        for (int o = 0; o < NPORTS; o++)
            for (int i = 0; i < NPORTS; i++)
                arb_req[o][i] = req[i] && (int'(req_dir[i]) == o) && !out_busy[o];
    end

    for (genvar o = 0; o < NPORTS; o++) begin : g_out
        rr_arbiter #(.N(NPORTS)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (arb_req[o]),
            .gnt (arb_gnt[o])
        );
    end

    always_comb begin
        grant     = '0;
        sel_ready = '0;
        for (int i = 0; i < NPORTS; i++)
            for (int o = 0; o < NPORTS; o++) begin
                grant[i] = grant[i] | arb_gnt[o][i];
                if (int'(lock_dir[i]) == o) sel_ready[i] = out_ready[o];
            end
    end

    always_comb begin
        out_valid = '0;
        out_flit  = '0;
        for (int o = 0; o < NPORTS; o++)
            for (int i = 0; i < NPORTS; i++)
                if (conn[o][i]) begin
                    out_valid[o] = out_valid[o] | head_valid[i];
                    out_flit[o]  = out_flit[o] | head_flit[i];
                end
    end
endmodule

// File: rtl/mesh_xy_router_chk.sv
module mesh_xy_router_chk
    import mesh_router_pkg::*;
#(
    parameter int FLIT_W = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NPORTS-1:0][FLIT_W-1:0] out_flit,
    input logic [NPORTS-1:0]             out_valid,
    input logic [NPORTS-1:0]             out_ready,
    input logic [NPORTS-1:0][NPORTS-1:0] conn
);
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_valid == '0));

    for (genvar o = 0; o < NPORTS; o++) begin : g_o
        p_single_owner_r4: assert property (@(posedge clk) disable iff (rst)
            $onehot0(conn[o]));

        p_valid_owned_r4: assert property (@(posedge clk) disable iff (rst)
            out_valid[o] |-> (|conn[o]));

        p_hold_stall_r7: assert property (@(posedge clk) disable iff (rst)
            (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_flit[o])));

        for (genvar i = 0; i < NPORTS; i++) begin : g_i
            p_release_on_xfer_r5: assert property (@(posedge clk) disable iff (rst)
                $fell(conn[o][i]) |-> $past(out_valid[o] && out_ready[o]));
        end
    end
endmodule

bind mesh_xy_router mesh_xy_router_chk #(.FLIT_W(FLIT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_flit  (out_flit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .conn      (conn)
);

// File: tb/mesh_xy_router_test.sv
module mesh_xy_router_test;
    localparam int NP = 5;
    localparam int PL = 0, PN = 1, PS = 2, PE = 3, PW = 4;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NP-1:0][31:0]   in_flit;
    logic [NP-1:0]         in_valid;
    logic [NP-1:0]         in_ready;
    logic [NP-1:0][31:0]   out_flit;
    logic [NP-1:0]         out_valid;
    logic [NP-1:0]         out_ready;

    mesh_xy_router #(.FLIT_W(32), .FIFO_DEPTH(4), .CNT_W(16), .MY_X(4'd1), .MY_Y(4'd1)) uut (
        .clk(clk), .rst(rst), .in_flit(in_flit), .in_valid(in_valid), .in_ready(in_ready),
        .out_flit(out_flit), .out_valid(out_valid), .out_ready(out_ready)
    );

    always #5 clk = ~clk;

    logic [31:0] tx_mem [NP][64];
    int          tx_cnt [NP];
    int          tx_idx [NP];
    logic [31:0] rx_mem [NP][64];
    int          rx_cyc [NP][64];
    int          rx_cnt [NP];
    logic [NP-1:0] in_fire, ready_mask;
    int cyc, errors, checks;
    bit done;

    initial begin
        in_flit = '0; in_valid = '0; out_ready = '0; ready_mask = '1; in_fire = '0;
        cyc = 0; errors = 0; checks = 0; done = 0;
        for (int p = 0; p < NP; p++) begin tx_cnt[p] = 0; tx_idx[p] = 0; rx_cnt[p] = 0; end
    end

    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            in_fire[p] = in_valid[p] && in_ready[p];
            if (!rst && out_valid[p] && out_ready[p] && rx_cnt[p] < 64) begin
                rx_mem[p][rx_cnt[p]] = out_flit[p];
                rx_cyc[p][rx_cnt[p]] = cyc;
                rx_cnt[p]++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        #1;
        for (int p = 0; p < NP; p++) begin
            if (in_fire[p]) tx_idx[p]++;
            in_fire[p]  = 1'b0;
            in_valid[p] = !rst && (tx_idx[p] < tx_cnt[p]);
            in_flit[p]  = (tx_idx[p] < 64) ? tx_mem[p][tx_idx[p]] : '0;
        end
        out_ready = ready_mask;
    end

    function automatic logic [31:0] pkt_flit(input logic [3:0] dx, input logic [3:0] dy,
                                             input int n, input logic [7:0] tag, input int k);
        if (k == 0)      return {tag, 16'h0000, dx, dy};
        else if (k == 1) return {tag, 8'h00, 16'(n)};
        else             return {tag, 8'hC0, 16'(k - 2)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_pkt(input int port, input logic [3:0] dx, input logic [3:0] dy,
                            input int n, input logic [7:0] tag);
        for (int k = 0; k < n + 2; k++) begin
            tx_mem[port][tx_cnt[port]] = pkt_flit(dx, dy, n, tag, k);
            tx_cnt[port]++;
        end
    endtask

    task automatic check_pkt(input int o, input int off, input logic [3:0] dx, input logic [3:0] dy,
                             input int n, input logic [7:0] tag, input string req);
        bit ok = (rx_cnt[o] >= off + n + 2);
        logic [31:0] a = '0, e = '0;
        for (int k = 0; k < n + 2 && ok; k++) begin
            a = rx_mem[o][off + k];
            e = pkt_flit(dx, dy, n, tag, k);
            if (a !== e) ok = 0;
        end
        check(ok, req, $sformatf("packet tag %0d on out %0d", tag, o), a, e);
    endtask

    task automatic fresh(input int wait_cycles);
        repeat (wait_cycles) @(posedge clk);
        #3;
        for (int p = 0; p < NP; p++) begin tx_cnt[p] = 0; tx_idx[p] = 0; rx_cnt[p] = 0; end
        ready_mask = '1;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        check(in_ready == 5'h1F, "R1", "in_ready after reset", 32'(in_ready), 32'h1F);
        check(out_valid == '0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
    endtask

    task automatic t_routing;
        fresh(2);
        push_pkt(PL, 4'd2, 4'd1, 1, 8'h11);
        push_pkt(PL, 4'd0, 4'd1, 1, 8'h12);
        push_pkt(PL, 4'd1, 4'd2, 1, 8'h13);
        push_pkt(PL, 4'd1, 4'd0, 1, 8'h14);
        push_pkt(PL, 4'd1, 4'd1, 1, 8'h15);
        push_pkt(PL, 4'd2, 4'd0, 1, 8'h16);
        push_pkt(PL, 4'd0, 4'd3, 1, 8'h17);
        repeat (60) @(posedge clk); #3;
        check_pkt(PE, 0, 4'd2, 4'd1, 1, 8'h11, "R2");
        check_pkt(PW, 0, 4'd0, 4'd1, 1, 8'h12, "R2");
        check_pkt(PN, 0, 4'd1, 4'd2, 1, 8'h13, "R2");
        check_pkt(PS, 0, 4'd1, 4'd0, 1, 8'h14, "R2");
        check_pkt(PL, 0, 4'd1, 4'd1, 1, 8'h15, "R2");
        check_pkt(PE, 3, 4'd2, 4'd0, 1, 8'h16, "R2 x-first");
        check_pkt(PW, 3, 4'd0, 4'd3, 1, 8'h17, "R2 x-first");
        check(rx_cnt[PE] == 6, "R2", "east flit count", 32'(rx_cnt[PE]), 32'd6);
    endtask

    task automatic t_format;
        fresh(2);
        push_pkt(PW, 4'd3, 4'd1, 5, 8'h21);
        repeat (30) @(posedge clk); #3;
        check_pkt(PE, 0, 4'd3, 4'd1, 5, 8'h21, "R3");
        check(rx_cnt[PE] == 7, "R3", "flit count 2+N", 32'(rx_cnt[PE]), 32'd7);
    endtask

    task automatic t_contention;
        bit ok;
        fresh(2);
        push_pkt(PN, 4'd2, 4'd1, 3, 8'h31);
        push_pkt(PS, 4'd2, 4'd1, 3, 8'h32);
        repeat (40) @(posedge clk); #3;
        ok = (rx_cnt[PE] == 10);
        if (rx_mem[PE][0][31:24] == 8'h31) begin
            for (int k = 0; k < 5; k++) ok &= (rx_mem[PE][k] === pkt_flit(4'd2, 4'd1, 3, 8'h31, k));
            for (int k = 0; k < 5; k++) ok &= (rx_mem[PE][5+k] === pkt_flit(4'd2, 4'd1, 3, 8'h32, k));
        end else begin
            for (int k = 0; k < 5; k++) ok &= (rx_mem[PE][k] === pkt_flit(4'd2, 4'd1, 3, 8'h32, k));
            for (int k = 0; k < 5; k++) ok &= (rx_mem[PE][5+k] === pkt_flit(4'd2, 4'd1, 3, 8'h31, k));
        end
        check(ok, "R4", "two contending packets not interleaved", 32'(rx_cnt[PE]), 32'd10);
    endtask

    task automatic t_round_robin;
        bit ok;
        logic [7:0] t0;
        fresh(2);
        push_pkt(PN, 4'd2, 4'd1, 1, 8'h41);
        push_pkt(PN, 4'd2, 4'd1, 1, 8'h42);
        push_pkt(PS, 4'd2, 4'd1, 1, 8'h51);
        push_pkt(PS, 4'd2, 4'd1, 1, 8'h52);
        repeat (50) @(posedge clk); #3;
        t0 = rx_mem[PE][0][31:24];
        ok = (rx_cnt[PE] == 12);
        if (t0 == 8'h41) ok &= rx_mem[PE][3][31:24] == 8'h51 && rx_mem[PE][6][31:24] == 8'h42 && rx_mem[PE][9][31:24] == 8'h52;
        else ok &= t0 == 8'h51 && rx_mem[PE][3][31:24] == 8'h41 && rx_mem[PE][6][31:24] == 8'h52 && rx_mem[PE][9][31:24] == 8'h42;
        check(ok, "R6", "grants alternate between inputs", {24'h0, rx_mem[PE][3][31:24]}, {24'h0, (t0 == 8'h41) ? 8'h51 : 8'h41});
    endtask

    task automatic t_release;
        fresh(2);
        push_pkt(PL, 4'd2, 4'd1, 0, 8'h61);
        push_pkt(PL, 4'd2, 4'd1, 2, 8'h62);
        push_pkt(PL, 4'd2, 4'd1, 1, 8'h63);
        repeat (40) @(posedge clk); #3;
        check_pkt(PE, 0, 4'd2, 4'd1, 0, 8'h61, "R5 zero payload");
        check_pkt(PE, 2, 4'd2, 4'd1, 2, 8'h62, "R5");
        check(rx_cyc[PE][2] == rx_cyc[PE][1] + 2, "R5", "gap after size-only packet",
              32'(rx_cyc[PE][2] - rx_cyc[PE][1]), 32'd2);
        check(rx_cyc[PE][6] == rx_cyc[PE][5] + 2, "R5", "gap after last payload flit",
              32'(rx_cyc[PE][6] - rx_cyc[PE][5]), 32'd2);
    endtask

    task automatic t_backpressure;
        logic [31:0] first;
        fresh(2);
        ready_mask = 5'b10111;
        push_pkt(PW, 4'd2, 4'd1, 6, 8'h71);
        repeat (12) @(posedge clk);
        @(negedge clk); #1;
        check(rx_cnt[PE] == 0, "R7", "no transfer while ready low", 32'(rx_cnt[PE]), 32'd0);
        check(in_ready[PW] == 1'b0, "R8", "in_ready low with full FIFO", 32'(in_ready[PW]), 32'd0);
        check(out_valid[PE] == 1'b1, "R7", "valid held during stall", 32'(out_valid[PE]), 32'd1);
        first = out_flit[PE];
        repeat (3) @(negedge clk); #1;
        check(out_flit[PE] == first && first == pkt_flit(4'd2, 4'd1, 6, 8'h71, 0), "R7",
              "flit stable during stall", out_flit[PE], pkt_flit(4'd2, 4'd1, 6, 8'h71, 0));
        ready_mask = '1;
        repeat (30) @(posedge clk); #3;
        check_pkt(PE, 0, 4'd2, 4'd1, 6, 8'h71, "R8 no loss");
        check(rx_cnt[PE] == 8, "R8", "no duplicates after stall", 32'(rx_cnt[PE]), 32'd8);
    endtask

    task automatic t_parallel;
        fresh(2);
        push_pkt(PW, 4'd2, 4'd1, 4, 8'h81);
        push_pkt(PE, 4'd0, 4'd1, 4, 8'h82);
        repeat (30) @(posedge clk); #3;
        check_pkt(PE, 0, 4'd2, 4'd1, 4, 8'h81, "R9");
        check_pkt(PW, 0, 4'd0, 4'd1, 4, 8'h82, "R9");
        check(rx_cyc[PE][5] == rx_cyc[PW][5], "R9", "disjoint paths finish together",
              32'(rx_cyc[PE][5]), 32'(rx_cyc[PW][5]));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        t_reset();
        t_routing();
        t_format();
        t_contention();
        t_round_robin();
        t_release();
        t_backpressure();
        t_parallel();
        finish_run();
    end
endmodule